// File: doc/BRIEF.md
# Floating-point compare flag unit

This unit orders two IEEE-754 operands for a floating-point coprocessor and reports the result as four condition flags: N, Z, C and V. Each operand arrives with a precision tag, single or double. Instead of a register value, the second operand can come from a built-in table of eight small constants, selected by a 3-bit index. In that case the constant takes the precision of the first operand.

Three command bits control the unit. One bit marks the transfer as a compare. A second bit makes an unordered result raise an invalid-operation pulse. A third bit flips the sign of the second operand before the two are compared. If either operand is a NaN, the result is unordered. The unordered result sets V and clears N and Z. C then copies a control bit from the status register.

When both register operands are single, the compare runs in single precision. In every other case, any single operand is first widened exactly to double, subnormals included. The ordering itself is combinational. The flags, a one-cycle valid strobe and the exception pulse are registered one clock after the input strobe.

Top module: `fp_cmp_flags`

## Requirements
- R1: A cycle with `valid_i` high and `op_i[2]` = 1 produces `flags_vld_o` = 1 exactly one clock later. A cycle without both produces no strobe, leaves `flags_o` unchanged and gives no `invalid_o` pulse.
- R2: For ordered operands, `flags_o` = {N,Z,C,V} (bit 3 down to bit 0). N=1 when first < second, Z=1 when they are equal, C=1 when second < first, and V=0. Exactly one of N, Z and C is set.
- R3: Positive zero and negative zero compare equal, giving `flags_o` = 4'b0100.
- R4: With `op_i[0]` = 1, only the sign bit of the second operand is inverted before the compare: bit 31 in single precision, bit 63 in double precision.
- R5: If either operand tested for NaN is a NaN (exponent all ones, fraction nonzero), the result is unordered. V=1, N=0, Z=0 and C=`ac_i`.
- R6: `invalid_o` pulses together with `flags_vld_o` only for an unordered result with `op_i[1]` = 1. It never pulses for the plain variant or for an ordered result.
- R7: When either register operand is tagged double (tag = 1), the compare is done in double precision. A single operand is widened exactly, including subnormals, so single 2^-149 equals double 2^-149.
- R8: With `b_imm_i` = 1, the second operand is the table entry at `imm_idx_i`. The table is 0:0, 1:1, 2:2, 3:3, 4:4, 5:5, 6:0.5, 7:10. The entry takes the precision of the first operand, and `b_i`, `b_dbl_i` and any NaN in `b_i` are ignored.
- R9: Infinities order by sign and magnitude: +inf is above every finite value and -inf is below every finite value.
- R10: After reset, `flags_o` = 0, `flags_vld_o` = 0 and `invalid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input strobe |
| op_i | input | 3 | [2] compare, [1] raise on unordered, [0] negate second operand |
| a_i | input | 64 | First operand; single precision uses bits [31:0] |
| a_dbl_i | input | 1 | First operand is double |
| b_i | input | 64 | Second register operand; single precision uses bits [31:0] |
| b_dbl_i | input | 1 | Second operand is double |
| b_imm_i | input | 1 | Take the second operand from the constant table |
| imm_idx_i | input | 3 | Constant table index |
| ac_i | input | 1 | Status control bit copied into C on an unordered result |
| flags_o | output | 4 | {N,Z,C,V} |
| flags_vld_o | output | 1 | Flags updated this cycle |
| invalid_o | output | 1 | Invalid-operation pulse |

## Verification
The assertions check the timing on every cycle: one strobe for each compare command and none otherwise, flags held between commands, and an exception pulse only alongside an unordered result. On every valid cycle they also check the shape of the flags: exactly one of N, Z and C when V is clear, and neither N nor Z when V is set. Only the directed scenarios can show that the ordering is correct. That covers signed zeros, infinities, negation, exact widening of subnormal singles, constant-table values with their precision choice, and C following `ac_i`.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_W = 32;
  localparam int DP_W = 64;

  // single-precision encodings of the immediate table
  function automatic logic [SP_W-1:0] imm_single(input logic [2:0] idx);
    case (idx)
      3'd0: imm_single = 32'h0000_0000;
      3'd1: imm_single = 32'h3F80_0000;
      3'd2: imm_single = 32'h4000_0000;
      3'd3: imm_single = 32'h4040_0000;
      3'd4: imm_single = 32'h4080_0000;
      3'd5: imm_single = 32'h40A0_0000;
      3'd6: imm_single = 32'h3F00_0000;
      default: imm_single = 32'h4120_0000;
    endcase
  endfunction

  // exact single -> double widening, subnormals normalised
  function automatic logic [DP_W-1:0] sp_to_dp(input logic [SP_W-1:0] s);
    logic [7:0]  e;
    logic [22:0] f;
    logic [4:0]  p;
    logic [63:0] m;
    e = s[30:23];
    f = s[22:0];
    p = '0;
    m = '0;
    if (e == 8'd0 && f == 23'd0) begin
      sp_to_dp = {s[31], 63'd0};
    end else if (e == 8'hFF) begin
      sp_to_dp = {s[31], 11'h7FF, f, 29'd0};
    end else if (e == 8'd0) begin
      for (int i = 0; i < 23; i++) if (f[i]) p = 5'(i);
      m = {41'd0, f} << (6'd52 - {1'b0, p});
      sp_to_dp = {s[31], 11'd874 + {6'd0, p}, m[51:0]};
    end else begin
      sp_to_dp = {s[31], {3'd0, e} + 11'd896, f, 29'd0};
    end
  endfunction
endpackage

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         eq_o,
  output logic         nan_a_o,
  output logic         nan_b_o
);
  localparam int EW = (W == 32) ? 8 : 11;
  localparam int FW = W - 1 - EW;

  logic [W-2:0] mag_a, mag_b;
  logic         both_zero;

  assign mag_a     = a_i[W-2:0];
  assign mag_b     = b_i[W-2:0];
  assign both_zero = (mag_a == '0) && (mag_b == '0);
  assign nan_a_o   = (&a_i[W-2:FW]) && (a_i[FW-1:0] != '0);
  assign nan_b_o   = (&b_i[W-2:FW]) && (b_i[FW-1:0] != '0);
  assign eq_o      = (a_i == b_i) || both_zero;

  always_comb begin
    if (both_zero)                 lt_o = 1'b0;
    else if (a_i[W-1] != b_i[W-1]) lt_o = a_i[W-1];
    else if (a_i[W-1])             lt_o = mag_a > mag_b;
    else                           lt_o = mag_a < mag_b;
  end
endmodule

// File: rtl/fcmp_operand_sel.sv
module fcmp_operand_sel
  import fcmp_pkg::*;
(
  input  logic [DP_W-1:0] a_i,
  input  logic            a_dbl_i,
  input  logic [DP_W-1:0] b_i,
  input  logic            b_dbl_i,
  input  logic            b_imm_i,
  input  logic [2:0]      imm_idx_i,
  input  logic            neg_i,
  output logic            use_dbl_o,
  output logic            chk_b_o,
  output logic [SP_W-1:0] a_sp_o,
  output logic [SP_W-1:0] b_sp_o,
  output logic [DP_W-1:0] a_dp_o,
  output logic [DP_W-1:0] b_dp_o
);
  logic [SP_W-1:0] imm_sp, b_sp_raw;
  logic [DP_W-1:0] b_dp_raw;

  assign imm_sp    = imm_single(imm_idx_i);
  // constant follows first operand's precision
  assign use_dbl_o = a_dbl_i | (~b_imm_i & b_dbl_i);
  assign chk_b_o   = ~b_imm_i;

  assign b_sp_raw = b_imm_i ? imm_sp : b_i[SP_W-1:0];
  assign b_dp_raw = b_imm_i ? sp_to_dp(imm_sp)
                  : (b_dbl_i ? b_i : sp_to_dp(b_i[SP_W-1:0]));

  assign a_sp_o = a_i[SP_W-1:0];
  assign a_dp_o = a_dbl_i ? a_i : sp_to_dp(a_i[SP_W-1:0]);
  assign b_sp_o = {b_sp_raw[SP_W-1] ^ neg_i, b_sp_raw[SP_W-2:0]};
  assign b_dp_o = {b_dp_raw[DP_W-1] ^ neg_i, b_dp_raw[DP_W-2:0]};
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
  import fcmp_pkg::*;
#(
  parameter int IMM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [DP_W-1:0]  a_i,
  input  logic             a_dbl_i,
  input  logic [DP_W-1:0]  b_i,
  input  logic             b_dbl_i,
  input  logic             b_imm_i,
  input  logic [IMM_W-1:0] imm_idx_i,
  input  logic             ac_i,
  output logic [3:0]       flags_o,
  output logic             flags_vld_o,
  output logic             invalid_o
);
  localparam int OP_CMP = 2;
  localparam int OP_EXC = 1;
  localparam int OP_NEG = 0;

  logic            use_dbl, chk_b;
  logic [SP_W-1:0] a_sp, b_sp;
  logic [DP_W-1:0] a_dp, b_dp;
  logic            lt_s, eq_s, nan_as, nan_bs;
  logic            lt_d, eq_d, nan_ad, nan_bd;
  logic            lt, eq, unord, fire;
  logic [3:0]      flags_d;

  fcmp_operand_sel i_sel (
    .a_i(a_i), .a_dbl_i(a_dbl_i), .b_i(b_i), .b_dbl_i(b_dbl_i),
    .b_imm_i(b_imm_i), .imm_idx_i(3'(imm_idx_i)), .neg_i(op_i[OP_NEG]),
    .use_dbl_o(use_dbl), .chk_b_o(chk_b),
    .a_sp_o(a_sp), .b_sp_o(b_sp), .a_dp_o(a_dp), .b_dp_o(b_dp)
  );

  fcmp_order #(.W(SP_W)) i_ord_sp (
    .a_i(a_sp), .b_i(b_sp), .lt_o(lt_s), .eq_o(eq_s),
    .nan_a_o(nan_as), .nan_b_o(nan_bs)
  );

  fcmp_order #(.W(DP_W)) i_ord_dp (
    .a_i(a_dp), .b_i(b_dp), .lt_o(lt_d), .eq_o(eq_d),
    .nan_a_o(nan_ad), .nan_b_o(nan_bd)
  );

  assign lt    = use_dbl ? lt_d : lt_s;
  assign eq    = use_dbl ? eq_d : eq_s;
  assign unord = use_dbl ? (nan_ad | (chk_b & nan_bd))
                         : (nan_as | (chk_b & nan_bs));
  assign fire  = valid_i & op_i[OP_CMP];

  always_comb begin
    if (unord) flags_d = {2'b00, ac_i, 1'b1};
    else       flags_d = {lt, eq, ~lt & ~eq, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o     <= '0;
      flags_vld_o <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      flags_vld_o <= fire;
      invalid_o   <= fire & unord & op_i[OP_EXC];
      if (fire) flags_o <= flags_d;
    end
  end

  // R1
  vld_follows_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[OP_CMP]) |=> flags_vld_o);
  // R1
  no_spurious_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i[OP_CMP]) |=> (!flags_vld_o && $stable(flags_o)));
  // R2
  ordered_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_vld_o && !flags_o[0]) |-> ($countones(flags_o[3:1]) == 1));
  // R5
  unord_clears_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_vld_o && flags_o[0]) |-> (!flags_o[3] && !flags_o[2]));
  // R6
  invalid_with_unord_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (flags_vld_o && flags_o[0]));
endmodule

// File: tb/test_fp_cmp_flags.sv
module test_fp_cmp_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic        a_dbl = 1'b0, b_dbl = 1'b0, b_imm = 1'b0, ac = 1'b0;
  logic [2:0]  idx = '0;
  logic [3:0]  flags;
  logic        vld, inv;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [2:0] CMP = 3'b100, CMPE = 3'b110, CNEG = 3'b101, CNEGE = 3'b111;
  localparam logic [3:0] FN = 4'b1000, FZ = 4'b0100, FC = 4'b0010;

  always #4 clk = ~clk;

  fp_cmp_flags i_fp_cmp_flags (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .a_dbl_i(a_dbl), .b_i(b), .b_dbl_i(b_dbl), .b_imm_i(b_imm),
    .imm_idx_i(idx), .ac_i(ac), .flags_o(flags), .flags_vld_o(vld), .invalid_o(inv)
  );

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {vld,inv,NZCV} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [63:0] av, input logic ad,
                       input logic [63:0] bv, input logic bd, input logic im,
                       input logic [2:0] ix, input logic acv);
    @(negedge clk);
    valid = 1'b1; op = o; a = av; a_dbl = ad; b = bv; b_dbl = bd;
    b_imm = im; idx = ix; ac = acv;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic cmp(input string tag, input logic [2:0] o, input logic [63:0] av,
                     input logic ad, input logic [63:0] bv, input logic bd,
                     input logic im, input logic [2:0] ix, input logic acv,
                     input logic [3:0] ef, input logic ei);
    issue(o, av, ad, bv, bd, im, ix, acv);
    chk(tag, {vld, inv, flags}, {1'b1, ei, ef});
  endtask

  task automatic t_reset();
    chk("R10 reset", {vld, inv, flags}, 6'b0);
  endtask

  task automatic t_order();
    cmp("R2 1<2",   CMP, 64'h3F80_0000, 0, 64'h4000_0000, 0, 0, 0, 0, FN, 0);
    cmp("R2 2>1",   CMP, 64'h4000_0000, 0, 64'h3F80_0000, 0, 0, 0, 0, FC, 0);
    cmp("R2 eq",    CMP, 64'h4040_0000, 0, 64'h4040_0000, 0, 0, 0, 0, FZ, 0);
    cmp("R2 -3<-2", CMPE, 64'hC040_0000, 0, 64'hC000_0000, 0, 0, 0, 0, FN, 0);
    cmp("R2 dbl",   CMP, 64'hC000_0000_0000_0000, 1, 64'h3FF0_0000_0000_0000, 1, 0, 0, 0, FN, 0);
  endtask

  task automatic t_zero_inf();
    cmp("R3 +0=-0", CMP, 64'h0, 0, 64'h8000_0000, 0, 0, 0, 0, FZ, 0);
    cmp("R3 dbl -0=+0", CMP, 64'h8000_0000_0000_0000, 1, 64'h0, 1, 0, 0, 0, FZ, 0);
    cmp("R9 +inf>1", CMP, 64'h7F80_0000, 0, 64'h3F80_0000, 0, 0, 0, 0, FC, 0);
    cmp("R9 -inf<0", CMP, 64'hFF80_0000, 0, 64'h0, 0, 0, 0, 0, FN, 0);
  endtask

  task automatic t_negate();
    cmp("R4 1 vs -1", CNEG, 64'h3F80_0000, 0, 64'h3F80_0000, 0, 0, 0, 0, FC, 0);
    cmp("R4 -2 vs -2", CNEG, 64'hC000_0000, 0, 64'h4000_0000, 0, 0, 0, 0, FZ, 0);
    cmp("R4 dbl bit63", CNEGE, 64'hBFF0_0000_0000_0000, 1, 64'h3FF0_0000_0000_0000, 1, 0, 0, 0, FZ, 0);
  endtask

  task automatic t_unordered();
    cmp("R5 nan a ac0", CMP, 64'h7FC0_0000, 0, 64'h3F80_0000, 0, 0, 0, 0, 4'b0001, 0);
    cmp("R5 nan a ac1 E", CMPE, 64'h7FC0_0000, 0, 64'h3F80_0000, 0, 0, 0, 1, 4'b0011, 1);
    cmp("R6 nan b dbl E", CMPE, 64'h3FF0_0000_0000_0000, 1, 64'h7FF0_0000_0000_0001, 1, 0, 0, 0, 4'b0001, 1);
    cmp("R6 plain no exc", CNEG, 64'h0, 0, 64'h7F80_0001, 0, 0, 0, 1, 4'b0011, 0);
  endtask

  task automatic t_mixed();
    cmp("R7 1.5s=1.5d", CMP, 64'h3FC0_0000, 0, 64'h3FF8_0000_0000_0000, 1, 0, 0, 0, FZ, 0);
    cmp("R7 denorm eq", CMP, 64'h0000_0001, 0, 64'h36A0_0000_0000_0000, 1, 0, 0, 0, FZ, 0);
    cmp("R7 denorm lt", CMP, 64'h0000_0001, 0, 64'h36B0_0000_0000_0000, 1, 0, 0, 0, FN, 0);
    cmp("R7 d vs s", CMP, 64'h3FF0_0000_0000_0000, 1, 64'h4000_0000, 0, 0, 0, 0, FN, 0);
  endtask

  task automatic t_imm();
    cmp("R8 s 5=#5", CMPE, 64'h40A0_0000, 0, 64'h7FC0_0000, 0, 1, 5, 0, FZ, 0);
    cmp("R8 d 0.5=#6", CMP, 64'h3FE0_0000_0000_0000, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 6, 0, FZ, 0);
    cmp("R8 d 10>#4", CMP, 64'h4024_0000_0000_0000, 1, 64'h0, 0, 1, 4, 0, FC, 0);
    cmp("R8 s 0.5<#7", CMP, 64'h3F00_0000, 0, 64'h0, 1, 1, 7, 0, FN, 0);
    cmp("R8 s -1=-#1", CNEG, 64'hBF80_0000, 0, 64'h0, 0, 1, 1, 0, FZ, 0);
    cmp("R8 s 3=#3", CMP, 64'h4040_0000, 0, 64'h0, 0, 1, 3, 0, FZ, 0);
  endtask

  task automatic t_no_cmd();
    cmp("R1 prime", CMP, 64'h4000_0000, 0, 64'h3F80_0000, 0, 0, 0, 0, FC, 0);
    issue(3'b011, 64'h7FC0_0000, 0, 64'h0, 0, 0, 0, 1);
    chk("R1 non-compare ignored", {vld, inv, flags}, {2'b00, FC});
    @(negedge clk);
    chk("R1 single strobe", {vld, inv, flags}, {2'b00, FC});
  endtask

  initial begin
    #1;
    t_reset();
    #20 rst_n = 1'b1;
    t_order();
    t_zero_inf();
    t_negate();
    t_unordered();
    t_mixed();
    t_imm();
    t_no_cmd();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule